// File: doc/BRIEF.md
# I2C Byte Shifter with Arbitration Monitor

This block holds the data byte of an I2C controller and moves it between the parallel side and the serial line. A frame has nine bit slots: eight data slots, most significant bit first, then one acknowledge slot. On each bit-clock enable pulse the block shifts out one bit and shifts in the level it sampled on SDA in the same slot. The register therefore always holds the byte that actually appeared on the bus. A master that loses arbitration can carry on as a slave receiver, and the received byte in the register is still correct.

In master-transmit mode every driven 1 is compared with the sampled line. In master-receive mode the block compares only the NACK it returns in the acknowledge slot. When a loss is detected, the block raises a sticky flag, enters a slave-receive condition and stops driving SDA. After a loss in transmit mode the frame runs on to its last slot, so the SCL generator keeps clocking until the byte is complete. After a loss in receive mode the frame is already finished, so no further clock pulses are requested. SCL timing itself comes from outside the block, through the bit-clock enable, which marks the SCL rising-phase sample point.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After synchronous reset, rd_byte is 0x00, and sda_low, frame_active, arb_lost and slave_rx are all 0.
- R2: A load_en pulse while frame_active is 0 writes load_byte into the register, and rd_byte shows it on the following cycle. A load_en pulse while frame_active is 1 leaves rd_byte unchanged.
- R3: mode_sel is encoded as 00 passive, 01 master-transmit, 10 master-receive, 11 passive. start_xfer while idle latches mode_sel and nack_sel and raises frame_active for nine bit_tick pulses: eight data slots and one acknowledge slot. start_xfer while frame_active is 1 is ignored, and so is its mode.
- R4: In master-transmit mode, sda_low during data slot k (k = 0..7, valid from the cycle after start or after the previous tick) is the inverse of bit 7-k of the loaded byte. In the acknowledge slot, SDA is released.
- R5: Each data-slot tick shifts the register one place toward bit 7 and enters sda_in at bit 0. After eight data ticks, the first sampled bit is in bit 7. The acknowledge tick does not shift.
- R6: In master-transmit mode, a data tick where a 1 is driven but sda_in is 0 sets arb_lost and slave_rx. From then on sda_low stays 0, frame_active stays 1 until the ninth tick, and the remaining bits are still shifted in.
- R7: In master-receive mode, sda_low is 0 during data slots. In the acknowledge slot, sda_low is 1 when nack_sel is 0 and 0 when nack_sel is 1. Arbitration is lost only at the acknowledge tick with nack_sel = 1 and sda_in = 0, and the frame ends on that same tick.
- R8: In passive mode, sda_low stays 0 and arbitration is never lost, whatever sda_in carries.
- R9: arb_lost stays set until an arb_clr pulse, even across later frames. slave_rx is cleared by the next accepted start_xfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Transfer mode, latched at start |
| start_xfer | input | 1 | Begin a nine-slot frame |
| nack_sel | input | 1 | Acknowledge-slot value in receive mode, 1 = NACK |
| load_en | input | 1 | Parallel byte write strobe |
| load_byte | input | 8 | Byte to write |
| bit_tick | input | 1 | One pulse per SCL sample point |
| sda_in | input | 1 | Sampled SDA level |
| arb_clr | input | 1 | Clears the arbitration-lost flag |
| sda_low | output | 1 | 1 = pull SDA low, 0 = release |
| rd_byte | output | 8 | Register contents, last byte seen on the bus |
| frame_active | output | 1 | Frame in progress; SCL may keep running |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| slave_rx | output | 1 | Block has yielded and is receiving as slave |

## Verification
The hardest case to reach from the ports is a transmit loss in the middle of a byte, followed by the remaining slots. To get there, the bench must supply a bus byte that matches the driven bits up to one chosen 1 and then carries a 0 there. It must also keep ticking after the flag rises, so that it can confirm SDA stays released, the frame continues, and the other master's bits end up in the register. The table covers losses at the first bit, an inner bit and the last data bit. A directed sequence then issues a load and a start in the middle of a frame and checks that neither disturbs the shift or the latched mode.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
  typedef enum logic [1:0] {
    XM_PASSIVE = 2'b00,
    XM_MTX     = 2'b01,
    XM_MRX     = 2'b10,
    XM_SPARE   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/i2cbs_slot_seq.sv
module i2cbs_slot_seq #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic             tick,
  output logic             busy,
  output logic [CNT_W-1:0] slot,
  output logic             data_ph,
  output logic             ack_ph
);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (start_ok) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (busy && tick) begin
      if (slot == ACK_SLOT) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign data_ph = busy && (slot < ACK_SLOT);
  assign ack_ph  = busy && (slot == ACK_SLOT);

  // R3: slot index never leaves the frame, and rests at zero when idle
  p_slot_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot <= ACK_SLOT));
  p_slot_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (slot == '0));
endmodule

// File: rtl/i2cbs_byte_reg.sv
module i2cbs_byte_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ok,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_ok)  q <= load_val;
    else if (shift_en) q <= {q[BYTE_W-2:0], bit_in};
  end

  // R5: a shift moves the old bits up one place
  p_shift_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_ok) |=> (q[BYTE_W-1:1] == $past(q[BYTE_W-2:0])));
endmodule

// File: rtl/i2cbs_arb_mon.sv
module i2cbs_arb_mon
  import i2cbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_req,
  input  logic       start_ok,
  input  logic       tick,
  input  logic       data_ph,
  input  logic       ack_ph,
  input  xfer_mode_e mode_q,
  input  logic       tx_bit,
  input  logic       nack_q,
  input  logic       sda_in,
  output logic       lose_now,
  output logic       lost_flag,
  output logic       yielded
);
  logic tx_clash, rx_clash;

  always_comb begin
    tx_clash = (mode_q == XM_MTX) && data_ph && tx_bit && !sda_in;
    rx_clash = (mode_q == XM_MRX) && ack_ph && nack_q && !sda_in;
    lose_now = tick && !yielded && (tx_clash || rx_clash);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lost_flag <= 1'b0;
      yielded   <= 1'b0;
    end else begin
      if (lose_now)       lost_flag <= 1'b1;
      else if (clear_req) lost_flag <= 1'b0;
      if (lose_now)       yielded <= 1'b1;
      else if (start_ok)  yielded <= 1'b0;
    end
  end

  // R9: the flag only falls on a clear request
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (lost_flag && !clear_req) |=> lost_flag);
  // R8: passive frames never yield
  p_passive_no_loss_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == XM_PASSIVE) |-> !lose_now);
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2cbs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              start_xfer,
  input  logic              nack_sel,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              bit_tick,
  input  logic              sda_in,
  input  logic              arb_clr,
  output logic              sda_low,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              frame_active,
  output logic              arb_lost,
  output logic              slave_rx
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);

  logic             busy, data_ph, ack_ph;
  logic [CNT_W-1:0] slot;
  logic             start_ok, load_ok, shift_en;
  logic             lose_now, lost_flag, yielded;
  logic [BYTE_W-1:0] q;
  xfer_mode_e       mode_in, mode_q;
  logic             nack_q, drv_q, first_msb;

  assign mode_in  = xfer_mode_e'(mode_sel);
  assign start_ok = start_xfer && !busy;
  assign load_ok  = load_en && !busy;
  assign shift_en = bit_tick && data_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= XM_PASSIVE;
      nack_q <= 1'b1;
    end else if (start_ok) begin
      mode_q <= mode_in;
      nack_q <= nack_sel;
    end
  end

  i2cbs_slot_seq #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_ok(start_ok), .tick(bit_tick),
    .busy(busy), .slot(slot), .data_ph(data_ph), .ack_ph(ack_ph)
  );

  i2cbs_byte_reg #(.BYTE_W(BYTE_W)) u_byte (
    .clk(clk), .rst(rst), .load_ok(load_ok), .load_val(load_byte),
    .shift_en(shift_en), .bit_in(sda_in), .q(q)
  );

  i2cbs_arb_mon u_arb (
    .clk(clk), .rst(rst), .clear_req(arb_clr), .start_ok(start_ok),
    .tick(bit_tick), .data_ph(data_ph), .ack_ph(ack_ph), .mode_q(mode_q),
    .tx_bit(q[BYTE_W-1]), .nack_q(nack_q), .sda_in(sda_in),
    .lose_now(lose_now), .lost_flag(lost_flag), .yielded(yielded)
  );

  assign first_msb = load_ok ? load_byte[BYTE_W-1] : q[BYTE_W-1];

  // SDA drive register: holds the level for the slot now on the bus
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
    end else if (start_ok) begin
      drv_q <= (mode_in == XM_MTX) && !first_msb;
    end else if (busy && bit_tick) begin
      if (ack_ph || lose_now || yielded)
        drv_q <= 1'b0;
      else if (slot < LAST_DATA)
        drv_q <= (mode_q == XM_MTX) && !q[BYTE_W-2];
      else
        drv_q <= (mode_q == XM_MRX) && !nack_q;
    end
  end

  assign sda_low      = drv_q;
  assign rd_byte      = q;
  assign frame_active = busy;
  assign arb_lost     = lost_flag;
  assign slave_rx     = yielded;

  // R6: a yielded block never pulls SDA
  p_release_yielded_r6: assert property (@(posedge clk) disable iff (rst)
    slave_rx |-> !sda_low);
  // R6: transmit loss inside the data bits keeps the frame (and SCL) going
  p_tx_loss_keeps_clock_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(slave_rx) && mode_q == XM_MTX && $past(slot) < CNT_W'(BYTE_W))
      |-> frame_active);
  // R7: receive-mode loss coincides with the end of the frame
  p_rx_loss_ends_frame_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(arb_lost) && mode_q == XM_MRX) |-> !frame_active);
  // R2: a load during a frame does not touch the byte
  p_load_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_active && load_en && !bit_tick) |=> $stable(rd_byte));
  // R8: passive frames leave SDA alone
  p_passive_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_active && mode_q == XM_PASSIVE) |-> !sda_low);
endmodule

// File: tb/i2c_byte_shifter_test.sv
module i2c_byte_shifter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       start_xfer = 1'b0, nack_sel = 1'b0, load_en = 1'b0;
  logic [7:0] load_byte = 8'h00;
  logic       bit_tick = 1'b0, sda_in = 1'b1, arb_clr = 1'b0;
  logic       sda_low, frame_active, arb_lost, slave_rx;
  logic [7:0] rd_byte;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_byte_shifter #(.BYTE_W(8)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .start_xfer(start_xfer),
    .nack_sel(nack_sel), .load_en(load_en), .load_byte(load_byte),
    .bit_tick(bit_tick), .sda_in(sda_in), .arb_clr(arb_clr),
    .sda_low(sda_low), .rd_byte(rd_byte), .frame_active(frame_active),
    .arb_lost(arb_lost), .slave_rx(slave_rx)
  );

  // fields: [20:19] mode, [18:11] tx byte, [10:3] bus byte, [2] ack level, [1] nack_sel, [0] loss expected
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 8'hA5, 8'hA5, 1'b0, 1'b0, 1'b0},
    {2'd1, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'hB6, 8'h93, 1'b1, 1'b0, 1'b1},
    {2'd1, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1},
    {2'd1, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h00, 8'h3C, 1'b0, 1'b0, 1'b0},
    {2'd2, 8'h00, 8'hC3, 1'b1, 1'b1, 1'b0},
    {2'd2, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b1},
    {2'd0, 8'h00, 8'hE7, 1'b0, 1'b1, 1'b0},
    {2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {2'd2, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [7:0] tx, input logic [7:0] bus,
                           input logic ackb, input logic nackc,
                           input logic exp_flag, input logic exp_yield);
    logic lost_m;
    logic drv_e;
    logic bitv;
    @(negedge clk); load_en = 1'b1; load_byte = tx;
    @(negedge clk); load_en = 1'b0;
    check(rd_byte == tx, "R2 load", rd_byte, tx);
    start_xfer = 1'b1; mode_sel = m; nack_sel = nackc;
    @(negedge clk); start_xfer = 1'b0;
    check(frame_active == 1'b1, "R3 start", frame_active, 1);
    check(slave_rx == 1'b0, "R9 slave_rx cleared by start", slave_rx, 0);
    lost_m = 1'b0;
    for (int s = 0; s < 9; s++) begin
      if (s < 8) drv_e = !lost_m && (m == 2'd1) && !tx[7-s];
      else       drv_e = !lost_m && (m == 2'd2) && !nackc;
      if (m == 2'd1)      check(sda_low == drv_e, "R4 tx drive", sda_low, drv_e);
      else if (m == 2'd2) check(sda_low == drv_e, "R7 rx drive", sda_low, drv_e);
      else                check(sda_low == drv_e, "R8 passive drive", sda_low, drv_e);
      bitv = (s < 8) ? bus[7-s] : ackb;
      bit_tick = 1'b1; sda_in = bitv;
      @(negedge clk); bit_tick = 1'b0; sda_in = 1'b1;
      if (s < 8 && m == 2'd1 && tx[7-s] && !bus[7-s]) lost_m = 1'b1;
      if (s == 8 && m == 2'd2 && nackc && !ackb) lost_m = 1'b1;
      if (s < 8) check(frame_active == 1'b1, "R6 frame continues", frame_active, 1);
    end
    check(frame_active == 1'b0, "R3 nine slots", frame_active, 0);
    check(rd_byte == bus, "R5 shifted byte", rd_byte, bus);
    check(arb_lost == exp_flag, "R6 R7 arb_lost", arb_lost, exp_flag);
    check(slave_rx == exp_yield, "R6 slave_rx", slave_rx, exp_yield);
    check(sda_low == 1'b0, "R4 released after frame", sda_low, 0);
  endtask

  task automatic clear_flag();
    @(negedge clk); arb_clr = 1'b1;
    @(negedge clk); arb_clr = 1'b0;
    check(arb_lost == 1'b0, "R9 clear", arb_lost, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_byte == 8'h00, "R1 rd_byte", rd_byte, 0);
    check(sda_low == 1'b0, "R1 sda_low", sda_low, 0);
    check(frame_active == 1'b0, "R1 frame_active", frame_active, 0);
    check(arb_lost == 1'b0, "R1 arb_lost", arb_lost, 0);
    check(slave_rx == 1'b0, "R1 slave_rx", slave_rx, 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][20:19], VEC[v][18:11], VEC[v][10:3], VEC[v][2], VEC[v][1],
                VEC[v][0], VEC[v][0]);
      clear_flag();
    end

    // R9: flag survives a later clean frame, slave_rx does not
    run_frame(2'd1, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    run_frame(2'd1, 8'hA5, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0);
    check(arb_lost == 1'b1, "R9 sticky", arb_lost, 1);
    clear_flag();

    // R2 and R3: load and start during a frame are ignored
    @(negedge clk); load_en = 1'b1; load_byte = 8'h3C;
    @(negedge clk); load_en = 1'b0;
    start_xfer = 1'b1; mode_sel = 2'd2; nack_sel = 1'b1;
    @(negedge clk); start_xfer = 1'b0;
    for (int s = 0; s < 3; s++) begin
      bit_tick = 1'b1; sda_in = (s < 2);
      @(negedge clk); bit_tick = 1'b0; sda_in = 1'b1;
    end
    load_en = 1'b1; load_byte = 8'hFF;
    @(negedge clk); load_en = 1'b0;
    check(rd_byte == 8'hE6, "R2 load ignored while busy", rd_byte, 8'hE6);
    start_xfer = 1'b1; mode_sel = 2'd1;
    @(negedge clk); start_xfer = 1'b0;
    for (int s = 3; s < 9; s++) begin
      check(sda_low == 1'b0, "R3 mode kept during frame", sda_low, 0);
      bit_tick = 1'b1; sda_in = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    check(frame_active == 1'b0, "R3 start ignored while busy", frame_active, 0);
    check(rd_byte == 8'hDF, "R5 bits shifted after ignored load", rd_byte, 8'hDF);
    check(arb_lost == 1'b0, "R7 nack with bus high no loss", arb_lost, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule